// File: doc/BRIEF.md
# Memory-Fed SPI Word Master

This block is the sending and receiving end of a single-slave SPI link. A small local word store is written ahead of time through a plain write port. Each accepted start request then moves one word out on MOSI and, at the same time, assembles the word the slave returns on MISO. The store's read pointer steps to the next entry after every completed frame, so a run of starts sends the stored words in sequence.

SCLK timing does not come from a divider inside the block. It comes from a one-cycle `sclk_tick` strobe, and each tick makes one SCLK edge. Clock polarity, clock phase, frame width (8 or 16 bits) and bit order are taken from pins when a start is accepted, and they stay fixed for the whole frame. Slave select is active low. It is held for the whole frame and released on the edge that ends the frame. In the same cycle a one-cycle `done` pulse appears and the received word is presented.

The received word has no ready: `rx_word` is valid in the `done` cycle and holds its value until the next frame completes. Nothing can stall the block, so a consumer that needs the word must capture it on `done`.

Top module: `spi_word_master`

## Requirements
- R1: After reset, `ss_n` is 1, `busy` and `done` are 0, `rd_ptr` is 0 and `sclk` equals the `cpol` pin.
- R2: While idle, `sclk` rests at the polarity level (0 for `cpol`=0, 1 for `cpol`=1). A frame of N bits makes exactly 2N SCLK edges, one for each `sclk_tick`, and ends with `sclk` back at the idle level.
- R3: With `cpha`=0, data is captured on the first edge of each SCLK cycle and MOSI changes on the second. With `cpha`=1, MOSI changes on the first edge and data is captured on the second. A slave that samples on the capture edges receives the transmitted word intact in all four polarity/phase modes.
- R4: The MISO bits sampled on the capture edges form `rx_word`, which is presented in the `done` cycle. For 8-bit frames, bits 15:8 of `rx_word` are 0.
- R5: `wide16`=1 selects 16-bit frames, which use bits 15:0 of the stored word. `wide16`=0 selects 8-bit frames, which use bits 7:0.
- R6: `lsb_first`=0 sends and receives the most significant bit of the frame first. `lsb_first`=1 sends and receives bit 0 first.
- R7: With `cpha`=0, the first data bit is on MOSI in the first cycle that `ss_n` is low, before any SCLK edge.
- R8: `ss_n` is low in every cycle in which `busy` is 1.
- R9: On the edge after the final SCLK edge, `done` pulses high for one cycle, `ss_n` returns high, `busy` falls and `rd_ptr` advances by one, wrapping at the store depth.
- R10: A `start` that arrives while `busy` is 1 has no effect. The frame in progress finishes unchanged, exactly one `done` follows, and `rd_ptr` advances only once.
- R11: Each frame sends the word at the store entry that `rd_ptr` addresses when the start is accepted. A stored 0x55 sent as an 8-bit frame appears on MOSI as 0,1,0,1,0,1,0,1 (MSB first).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_we | input | 1 | Write strobe for the word store |
| mem_waddr | input | ADDR_W | Word store write address |
| mem_wdata | input | WORD_W | Word store write data |
| start | input | 1 | Begin one frame; accepted only while idle |
| cpol | input | 1 | Idle level of SCLK |
| cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| wide16 | input | 1 | 1: 16-bit frame; 0: 8-bit frame |
| lsb_first | input | 1 | 1: bit 0 first; 0: top bit first |
| sclk_tick | input | 1 | One SCLK edge per high cycle while busy |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock to the slave |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |
| rx_word | output | WORD_W | Received word, valid from `done` |
| rd_ptr | output | ADDR_W | Word store entry used by the next frame |

## Verification
The bench runs all four polarity/phase pairs, both frame widths and both bit orders. A design that mixed up the capture and change edges would hand the bench's slave model shifted or duplicated bits, and a design that ignored `wide16` would show the wrong SCLK edge count. For phase 0, the bench checks MOSI at the moment select asserts; a design that held the first bit back until the first edge fails that check. A second start is issued in the middle of a frame; a design that accepted it would produce an extra `done` with no expected entry, or a pointer that is one too far. Enough frames are sent to make the read pointer wrap past the last store entry.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic wide;
    logic lsb;
  } spi_mode_t;
endpackage

// File: rtl/spi_wm_mem.sv
module spi_wm_mem #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/spi_wm_seq.sv
module spi_wm_seq
  import spi_wm_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       sclk_tick,
  input  spi_mode_t                  mode_in,
  output spi_mode_t                  mode,
  output logic                       load,
  output logic                       smp,
  output logic                       chg,
  output logic                       last,
  output logic [$clog2(WORD_W):0]    idx,
  output logic                       busy,
  output logic                       ss_n,
  output logic                       sclk,
  output logic                       done,
  output logic [ADDR_W-1:0]          rd_ptr
);
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int EDGE_W = $clog2(2 * WORD_W);
  localparam logic [EDGE_W:0] LAST_WIDE   = (EDGE_W+1)'(2 * WORD_W - 1);
  localparam logic [EDGE_W:0] LAST_NARROW = (EDGE_W+1)'(2 * NARROW_W - 1);

  logic              busy_q, ss_q, sclk_q, done_q;
  logic [EDGE_W-1:0] edge_q;
  logic [ADDR_W-1:0] ptr_q;
  spi_mode_t         mode_q;
  logic              adv;
  logic [EDGE_W:0]   last_e;

  assign load   = start & ~busy_q;
  assign adv    = busy_q & sclk_tick;
  assign smp    = adv & (mode_q.cpha ? edge_q[0] : ~edge_q[0]);
  assign chg    = adv & ~smp;
  assign last_e = mode_q.wide ? LAST_WIDE : LAST_NARROW;
  assign last   = adv & ({1'b0, edge_q} == last_e);
  assign idx    = (!mode_q.cpha && chg) ? (IDX_W+1)'(({1'b0, edge_q} + 1'b1) >> 1)
                                        : (IDX_W+1)'(edge_q >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ss_q   <= 1'b1;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      edge_q <= '0;
      ptr_q  <= '0;
      mode_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        ss_q   <= 1'b0;
        sclk_q <= mode_in.cpol;
        edge_q <= '0;
        mode_q <= mode_in;
      end else if (adv) begin
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          ss_q   <= 1'b1;
          done_q <= 1'b1;
          ptr_q  <= ptr_q + 1'b1;
        end
      end else if (!busy_q) begin
        sclk_q <= mode_in.cpol;
      end
    end
  end

  assign mode   = mode_q;
  assign busy   = busy_q;
  assign ss_n   = ss_q;
  assign sclk   = sclk_q;
  assign done   = done_q;
  assign rd_ptr = ptr_q;

  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (sclk_q == mode_q.cpol));
  assert_select_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !ss_q);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (ss_q && !busy_q));
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> ($stable(ptr_q) && $stable(mode_q)));
endmodule

// File: rtl/spi_wm_shift.sv
module spi_wm_shift #(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    ld_cpha,
  input  logic                    ld_wide,
  input  logic                    ld_lsb,
  input  logic [WORD_W-1:0]       tx_word,
  input  logic                    wide,
  input  logic                    lsb,
  input  logic                    smp,
  input  logic                    chg,
  input  logic                    last,
  input  logic [$clog2(WORD_W):0] idx,
  input  logic                    miso,
  output logic                    mosi,
  output logic [WORD_W-1:0]       rx_word
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W:0] LEN_WIDE   = (IDX_W+1)'(WORD_W);
  localparam logic [IDX_W:0] LEN_NARROW = (IDX_W+1)'(NARROW_W);

  logic [WORD_W-1:0] tx_q, rx_q, rx_nx, rx_out_q;
  logic              mosi_q;
  logic [IDX_W:0]    len;
  logic [IDX_W-1:0]  pos;

  function automatic logic [IDX_W-1:0] bitpos(input logic [IDX_W:0] i,
                                              input logic [IDX_W:0] n,
                                              input logic           lsb_f);
    logic [IDX_W:0] p;
    p = lsb_f ? i : (n - 1'b1 - i);
    return p[IDX_W-1:0];
  endfunction

  assign len = wide ? LEN_WIDE : LEN_NARROW;
  assign pos = bitpos(idx, len, lsb);

  always_comb begin
    rx_nx = rx_q;
    if (smp) rx_nx[pos] = miso;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q     <= '0;
      rx_q     <= '0;
      rx_out_q <= '0;
      mosi_q   <= 1'b0;
    end else if (load) begin
      tx_q   <= tx_word;
      rx_q   <= '0;
      mosi_q <= ld_cpha ? 1'b0
              : tx_word[bitpos('0, ld_wide ? LEN_WIDE : LEN_NARROW, ld_lsb)];
    end else begin
      rx_q <= rx_nx;
      if (chg && (idx < len)) mosi_q <= tx_q[pos];
      if (last) rx_out_q <= rx_nx;
    end
  end

  assign mosi    = mosi_q;
  assign rx_word = rx_out_q;
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_wm_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_waddr,
  input  logic [WORD_W-1:0] mem_wdata,
  input  logic              start,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              wide16,
  input  logic              lsb_first,
  input  logic              sclk_tick,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              ss_n,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic [ADDR_W-1:0] rd_ptr
);
  localparam int IDX_W = $clog2(WORD_W);

  spi_mode_t         mode_in, mode;
  logic              load, smp, chg, last;
  logic [IDX_W:0]    idx;
  logic [WORD_W-1:0] tx_word;
  logic [ADDR_W-1:0] ptr;

  assign mode_in = '{cpol: cpol, cpha: cpha, wide: wide16, lsb: lsb_first};

  spi_wm_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(tx_word)
  );

  spi_wm_seq #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sclk_tick(sclk_tick),
    .mode_in(mode_in), .mode(mode), .load(load), .smp(smp), .chg(chg),
    .last(last), .idx(idx), .busy(busy), .ss_n(ss_n), .sclk(sclk),
    .done(done), .rd_ptr(ptr)
  );

  spi_wm_shift #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ld_cpha(mode_in.cpha), .ld_wide(mode_in.wide), .ld_lsb(mode_in.lsb),
    .tx_word(tx_word), .wide(mode.wide), .lsb(mode.lsb),
    .smp(smp), .chg(chg), .last(last), .idx(idx), .miso(miso),
    .mosi(mosi), .rx_word(rx_word)
  );

  assign rd_ptr = ptr;

  assert_narrow_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode.wide) |-> (rx_word[WORD_W-1:NARROW_W] == '0));
endmodule

// File: tb/tb_spi_word_master.sv
module tb_spi_word_master;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_we = 1'b0;
  logic [ADDR_W-1:0] mem_waddr = '0;
  logic [WORD_W-1:0] mem_wdata = '0;
  logic start = 1'b0, cpol = 1'b0, cpha = 1'b0, wide16 = 1'b0, lsb_first = 1'b0;
  logic sclk_tick = 1'b0, miso = 1'b0;
  logic sclk, mosi, ss_n, busy, done;
  logic [WORD_W-1:0] rx_word;
  logic [ADDR_W-1:0] rd_ptr;

  int n_chk = 0, n_bad = 0;
  logic [WORD_W-1:0] q_tx[$], q_rx[$];
  logic [ADDR_W-1:0] exp_ptr = '0;
  logic [WORD_W-1:0] slave_word = '0;
  logic [WORD_W-1:0] cap;
  int edges = 0;
  logic prev_ss = 1'b1, prev_sclk = 1'b0;
  int tick_div = 0;

  always #10 clk = ~clk;

  spi_word_master #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .start(start), .cpol(cpol), .cpha(cpha),
    .wide16(wide16), .lsb_first(lsb_first), .sclk_tick(sclk_tick), .miso(miso),
    .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .busy(busy), .done(done),
    .rx_word(rx_word), .rd_ptr(rd_ptr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bpos(input int i, input int n, input logic lsb);
    return lsb ? i : n - 1 - i;
  endfunction

  function automatic int flen();
    return wide16 ? 16 : 8;
  endfunction

  function automatic logic [WORD_W-1:0] wmask(input logic [WORD_W-1:0] w);
    return wide16 ? w : {8'h00, w[7:0]};
  endfunction

  // sclk_tick strobe, one every fourth cycle
  always @(negedge clk) begin
    tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
    sclk_tick <= (tick_div == 3);
  end

  // Slave model and monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ss && !ss_n) begin
        edges = 0;
        cap = '0;
        if (!cpha) begin
          miso <= slave_word[bpos(0, flen(), lsb_first)];
          check("R7 first bit at select", mosi, q_tx.size() > 0 ?
                q_tx[0][bpos(0, flen(), lsb_first)] : 1'b0);
        end
      end else if (!prev_ss && sclk !== prev_sclk) begin
        if (cpha ? (edges % 2 == 1) : (edges % 2 == 0))
          cap[bpos(edges / 2, flen(), lsb_first)] = mosi;
        else begin
          int ni;
          ni = cpha ? edges / 2 : (edges + 1) / 2;
          if (ni < flen()) miso <= slave_word[bpos(ni, flen(), lsb_first)];
        end
        edges++;
      end
      if (done) begin
        if (q_tx.size() == 0) begin
          check("R10 unexpected done", 1, 0);
        end else begin
          logic [WORD_W-1:0] et, er;
          et = q_tx.pop_front();
          er = q_rx.pop_front();
          check("R3/R6/R11 mosi word", cap, et);
          check("R4/R5 rx_word", rx_word, er);
          check("R2/R5 sclk edges", edges, 2 * flen());
          check("R2 sclk back at idle", sclk, cpol);
          check("R9 pointer advance", rd_ptr, exp_ptr);
          check("R9 select released", ss_n, 1);
        end
      end
    end
    prev_ss = ss_n;
    prev_sclk = sclk;
  end

  // Driver: stores the word, pushes expectations, starts the frame
  task automatic run_frame(input logic [WORD_W-1:0] tx, input logic [WORD_W-1:0] sw,
                           input logic p, input logic h, input logic w,
                           input logic l, input bit restart);
    @(negedge clk);
    mem_we = 1'b1; mem_waddr = exp_ptr; mem_wdata = tx;
    cpol = p; cpha = h; wide16 = w; lsb_first = l; slave_word = sw;
    @(negedge clk);
    mem_we = 1'b0;
    repeat (2) @(negedge clk);
    q_tx.push_back(wmask(tx));
    q_rx.push_back(wmask(sw));
    exp_ptr = exp_ptr + 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 select low while busy", {busy, ss_n}, 2'b10);
    if (restart) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    check("R10 idle after frame", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ss_n", ss_n, 1);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 rd_ptr", rd_ptr, 0);
    check("R1 sclk", sclk, cpol);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_frame(16'h0055, 16'h00A3, 0, 0, 0, 0, 0);   // R11 0x55 frame
    run_frame(16'hBEEF, 16'h1234, 0, 1, 1, 0, 0);   // R3 mode 0/1
    run_frame(16'hC3A5, 16'h5A0F, 1, 0, 1, 0, 0);   // R3 mode 1/0
    run_frame(16'h8001, 16'hF00D, 1, 1, 1, 0, 0);   // R3 mode 1/1
    run_frame(16'h12F1, 16'h0081, 0, 0, 0, 1, 0);   // R6 lsb first 8
    run_frame(16'h7E42, 16'hA5C3, 1, 1, 1, 1, 0);   // R6 lsb first 16
    run_frame(16'hFF80, 16'hFF01, 1, 0, 0, 0, 0);   // R5 narrow ignores top byte
    run_frame(16'h3C69, 16'h9696, 0, 1, 1, 1, 1);   // R10 start during frame
    run_frame(16'h0F0F, 16'hC001, 1, 1, 0, 1, 0);   // R9 pointer wrap
    run_frame(16'hA001, 16'h4002, 0, 0, 1, 0, 0);
    check("R9 pointer after wrap", rd_ptr, 3'd2);
    check("R10 no stray frames", q_tx.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule